// File: doc/BRIEF.md
# Dual-Mode Serial Receive Deserializer

This block sits behind a demodulator and turns its recovered bit stream into bytes for a host. Each valid bit comes with a one-cycle strobe. A mode register selects one of two ways to form bytes. In raw synchronous packing, every eight strobed bits become one byte. In framed asynchronous reception, the block looks for a start bit, collects seven or eight data bits, optionally checks a parity bit, and then samples one stop bit.

Every finished byte goes into a receive data register and sets a ready flag. If a new byte arrives while the previous one is still unread, an overrun flag is raised. Parity and stop-bit faults are kept as sticky flags. A read pulse on the data register clears the ready flag. A separate read pulse on the flags register clears the three error flags.

The host may change the mode register only between characters.

Top module: `mrx_deser`

## Requirements
- R1: With mode_reg[5]=0, every eight strobed bits form one byte, and the first bit received lands in rx_data[0]. The byte appears after the clock edge that takes the eighth strobed bit.
- R2: With mode_reg[5]=1, the receiver stays idle while strobed bits are 1. A strobed 0 starts a character.
- R3: In asynchronous mode, mode_reg[0]=1 selects eight data bits and mode_reg[0]=0 selects seven. Data bits are stored first-received into rx_data[0]. With seven bits, rx_data[7] is written 0.
- R4: mode_reg[2]=1 adds a parity bit after the data bits. mode_reg[1]=1 selects even parity and mode_reg[1]=0 selects odd parity. A wrong parity bit sets flags[7].
- R5: In asynchronous mode, the stop bit is sampled after the data bits and the optional parity bit. If the stop bit is 0, the byte is still stored and flags[6] is set. The receiver then ignores 0s until it has seen a 1, and only after that does it accept a new start bit.
- R6: flags[3] (ready) is set whenever a byte is stored. It is cleared by data_rd unless a store happens in the same cycle.
- R7: flags[4] (overrun) is set when a byte is stored while flags[3] is set and data_rd is low in that cycle.
- R8: flags_rd clears flags[7], flags[6] and flags[4]. A setting event in the same cycle takes priority over the clear.
- R9: After reset, rx_data and flags are 0. Flag bits 5, 2, 1 and 0 are always 0.
- R10: bit_in is ignored in every cycle where bit_stb is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe marking a valid received bit |
| bit_in | input | 1 | Received bit value |
| mode_reg | input | 8 | Mode: bit5 async, bit2 parity enable, bit1 even parity, bit0 eight data bits |
| data_rd | input | 1 | Host read pulse on the data register |
| flags_rd | input | 1 | Host read pulse on the flags register |
| rx_data | output | 8 | Receive data register |
| flags | output | 8 | Flags: bit7 parity error, bit6 framing error, bit4 overrun, bit3 ready |

## Verification
The assertions check the following on every cycle:
- the ready, overrun and error-clear rules around each internal store pulse;
- that rx_data holds its value between stores;
- that stores happen only on strobed cycles;
- that the unused flag bits stay 0;
- that seven-bit bytes have a cleared top bit.

Only the bench scenarios can show the bit ordering of packed bytes, the parity sense for each mode setting, the hunt for a 1 after a bad stop bit, and that idle marks never start a character. These scenarios are compared against a queue-based reference model on every clock.

// File: rtl/mrx_pkg.sv
package mrx_pkg;
  localparam int MODE_LEN8   = 0;
  localparam int MODE_EVEN   = 1;
  localparam int MODE_PAREN  = 2;
  localparam int MODE_ASYNC  = 5;
  localparam int FLG_RDY     = 3;
  localparam int FLG_OVF     = 4;
  localparam int FLG_FERR    = 6;
  localparam int FLG_PERR    = 7;
  localparam int FLG_W       = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DATA,
    ST_PAR,
    ST_STOP,
    ST_HUNT
  } rx_st_t;
endpackage

// File: rtl/mrx_framer.sv
module mrx_framer
  import mrx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bit_stb,
  input  logic          bit_in,
  input  logic          async_mode,
  input  logic          len8,
  input  logic          par_en,
  input  logic          par_even,
  output logic          ld,
  output logic [DW-1:0] ld_byte,
  output logic          ld_perr,
  output logic          ld_ferr
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST_FULL  = CW'(DW - 1);
  localparam logic [CW-1:0] LAST_SHORT = CW'(DW - 2);

  rx_st_t        st_q, st_n;
  logic [DW-1:0] sh_q, sh_n, sh_in;
  logic [CW-1:0] cnt_q, cnt_n, last_idx;
  logic          par_q, par_n;

  assign sh_in    = {bit_in, sh_q[DW-1:1]};
  assign last_idx = len8 ? LAST_FULL : LAST_SHORT;

  always_comb begin
    st_n    = st_q;
    sh_n    = sh_q;
    cnt_n   = cnt_q;
    par_n   = par_q;
    ld      = 1'b0;
    ld_byte = sh_q;
    ld_perr = 1'b0;
    ld_ferr = 1'b0;
    if (bit_stb) begin
      if (!async_mode) begin
        st_n = ST_IDLE;
        sh_n = sh_in;
        if (cnt_q == LAST_FULL) begin
          ld      = 1'b1;
          ld_byte = sh_in;
          cnt_n   = '0;
        end else begin
          cnt_n = cnt_q + 1'b1;
        end
      end else begin
        unique case (st_q)
          ST_IDLE: begin
            if (!bit_in) begin
              st_n  = ST_DATA;
              cnt_n = '0;
              par_n = 1'b0;
            end
          end
          ST_DATA: begin
            sh_n  = sh_in;
            par_n = par_q ^ bit_in;
            if (cnt_q == last_idx) begin
              cnt_n = '0;
              st_n  = par_en ? ST_PAR : ST_STOP;
            end else begin
              cnt_n = cnt_q + 1'b1;
            end
          end
          ST_PAR: begin
            par_n = par_q ^ bit_in;
            st_n  = ST_STOP;
          end
          ST_STOP: begin
            ld      = 1'b1;
            ld_byte = len8 ? sh_q : {1'b0, sh_q[DW-1:1]};
            ld_perr = par_en & ~(par_q ^ par_even);
            ld_ferr = ~bit_in;
            st_n    = bit_in ? ST_IDLE : ST_HUNT;
          end
          ST_HUNT: begin
            if (bit_in) st_n = ST_IDLE;
          end
          default: st_n = ST_IDLE;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      sh_q  <= '0;
      cnt_q <= '0;
      par_q <= 1'b0;
    end else if (bit_stb) begin
      st_q  <= st_n;
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
      par_q <= par_n;
    end
  end
endmodule

// File: rtl/mrx_hold.sv
module mrx_hold #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [DW-1:0] ld_byte,
  input  logic          ld_perr,
  input  logic          ld_ferr,
  input  logic          data_rd,
  input  logic          flags_rd,
  output logic [DW-1:0] rx_data,
  output logic          rdy,
  output logic          ovf,
  output logic          perr,
  output logic          ferr
);
  logic rdy_n, ovf_n, perr_n, ferr_n;
  logic set_ovf;

  assign set_ovf = ld & rdy & ~data_rd;

  always_comb begin
    rdy_n  = ld ? 1'b1 : (data_rd ? 1'b0 : rdy);
    ovf_n  = set_ovf ? 1'b1 : (flags_rd ? 1'b0 : ovf);
    perr_n = (ld & ld_perr) ? 1'b1 : (flags_rd ? 1'b0 : perr);
    ferr_n = (ld & ld_ferr) ? 1'b1 : (flags_rd ? 1'b0 : ferr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_data <= '0;
    end else if (ld) begin
      rx_data <= ld_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy  <= 1'b0;
      ovf  <= 1'b0;
      perr <= 1'b0;
      ferr <= 1'b0;
    end else begin
      rdy  <= rdy_n;
      ovf  <= ovf_n;
      perr <= perr_n;
      ferr <= ferr_n;
    end
  end
endmodule

// File: rtl/mrx_deser.sv
module mrx_deser
  import mrx_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             bit_in,
  input  logic [7:0]       mode_reg,
  input  logic             data_rd,
  input  logic             flags_rd,
  output logic [DW-1:0]    rx_data,
  output logic [FLG_W-1:0] flags
);
  logic          ld_w;
  logic [DW-1:0] ld_byte_w;
  logic          ld_perr_w, ld_ferr_w;
  logic          rdy_w, ovf_w, perr_w, ferr_w;

  mrx_framer #(.DW(DW)) framer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_stb    (bit_stb),
    .bit_in     (bit_in),
    .async_mode (mode_reg[MODE_ASYNC]),
    .len8       (mode_reg[MODE_LEN8]),
    .par_en     (mode_reg[MODE_PAREN]),
    .par_even   (mode_reg[MODE_EVEN]),
    .ld         (ld_w),
    .ld_byte    (ld_byte_w),
    .ld_perr    (ld_perr_w),
    .ld_ferr    (ld_ferr_w)
  );

  mrx_hold #(.DW(DW)) hold_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld       (ld_w),
    .ld_byte  (ld_byte_w),
    .ld_perr  (ld_perr_w),
    .ld_ferr  (ld_ferr_w),
    .data_rd  (data_rd),
    .flags_rd (flags_rd),
    .rx_data  (rx_data),
    .rdy      (rdy_w),
    .ovf      (ovf_w),
    .perr     (perr_w),
    .ferr     (ferr_w)
  );

  always_comb begin
    flags           = '0;
    flags[FLG_RDY]  = rdy_w;
    flags[FLG_OVF]  = ovf_w;
    flags[FLG_FERR] = ferr_w;
    flags[FLG_PERR] = perr_w;
  end
endmodule

// File: rtl/mrx_deser_chk.sv
module mrx_deser_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bit_stb,
  input logic [7:0] mode_reg,
  input logic       data_rd,
  input logic       flags_rd,
  input logic [7:0] rx_data,
  input logic [7:0] flags,
  input logic       ld_w
);
  // R6
  ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_w |=> flags[3]);

  // R6
  ready_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && !ld_w) |=> !flags[3]);

  // R7
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_w && flags[3] && !data_rd) |=> flags[4]);

  // R8
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_rd && !ld_w) |=> (flags[7:6] == 2'b00 && !flags[4]));

  // R1
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_w |=> $stable(rx_data));

  // R10
  strobe_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_w |-> bit_stb);

  // R3
  short_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_w && mode_reg[5] && !mode_reg[0]) |=> !rx_data[7]);

  // R9
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[5] == 1'b0 && flags[2:0] == 3'b000));
endmodule

bind mrx_deser mrx_deser_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .bit_stb  (bit_stb),
  .mode_reg (mode_reg),
  .data_rd  (data_rd),
  .flags_rd (flags_rd),
  .rx_data  (rx_data),
  .flags    (flags),
  .ld_w     (ld_w)
);

// File: tb/mrx_deser_tb.sv
module mrx_deser_tb_top;
  logic       clk;
  logic       rst_n;
  logic       stb;
  logic       bin;
  logic [7:0] mode;
  logic       drd;
  logic       frd;
  logic [7:0] rx_data;
  logic [7:0] flags;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  mrx_deser dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_stb  (stb),
    .bit_in   (bin),
    .mode_reg (mode),
    .data_rd  (drd),
    .flags_rd (frd),
    .rx_data  (rx_data),
    .flags    (flags)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // Behavioural reference model
  bit   q[$];
  bit   m_act, m_hunt;
  logic [7:0] m_data;
  bit   m_rdy, m_ovf, m_pe, m_fe;

  always @(posedge clk) begin
    bit ld, pe, fe;
    logic [7:0] byt;
    int len, need, ones;
    ld = 0; pe = 0; fe = 0; byt = 8'h00;
    if (!rst_n) begin
      q.delete();
      m_act = 0; m_hunt = 0; m_data = 8'h00;
      m_rdy = 0; m_ovf = 0; m_pe = 0; m_fe = 0;
    end else begin
      if (stb) begin
        if (!mode[5]) begin
          q.push_back(bin);
          if (q.size() == 8) begin
            for (int i = 0; i < 8; i++) byt[i] = q[i];
            ld = 1;
            q.delete();
          end
        end else if (m_hunt) begin
          if (bin) m_hunt = 0;
        end else if (!m_act) begin
          if (!bin) begin
            m_act = 1;
            q.delete();
          end
        end else begin
          q.push_back(bin);
          len  = mode[0] ? 8 : 7;
          need = len + (mode[2] ? 1 : 0) + 1;
          if (q.size() == need) begin
            ones = 0;
            for (int i = 0; i < len; i++) begin
              byt[i] = q[i];
              ones += q[i];
            end
            if (mode[2]) begin
              ones += q[len];
              pe = mode[1] ? (ones % 2 == 1) : (ones % 2 == 0);
            end
            fe = !bin;
            ld = 1;
            m_act = 0;
            m_hunt = !bin;
            q.delete();
          end
        end
      end
      if (ld && m_rdy && !drd) m_ovf = 1;
      else if (frd) m_ovf = 0;
      if (ld && pe) m_pe = 1;
      else if (frd) m_pe = 0;
      if (ld && fe) m_fe = 1;
      else if (frd) m_fe = 0;
      if (ld) m_rdy = 1;
      else if (drd) m_rdy = 0;
      if (ld) m_data = byt;
    end
  end

  // Model comparison every clock
  always @(negedge clk) begin
    logic [7:0] ef;
    if (rst_n && !done) begin
      ef = {m_pe, m_fe, 1'b0, m_ovf, m_rdy, 3'b000};
      checks++;
      if (rx_data !== m_data) begin
        errors++;
        $display("FAIL %s model data actual %h expected %h",
                 mode[5] ? "R3" : "R1", rx_data, m_data);
      end
      checks++;
      if (flags !== ef) begin
        errors++;
        $display("FAIL R6 model flags actual %h expected %h", flags, ef);
      end
    end
  end

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send_bit(input bit b, input bit rf = 0);
    @(negedge clk);
    stb = 1'b1; bin = b; frd = rf;
    @(negedge clk);
    stb = 1'b0; frd = 1'b0;
  endtask

  task automatic send_char(input logic [7:0] v, input int len, input bit pen,
                           input bit pbit, input bit stop, input bit rf_last = 0);
    send_bit(1'b0);
    for (int i = 0; i < len; i++) send_bit(v[i]);
    if (pen) send_bit(pbit);
    send_bit(stop, rf_last);
  endtask

  task automatic rd_data();
    @(negedge clk); drd = 1'b1;
    @(negedge clk); drd = 1'b0;
  endtask

  task automatic rd_flags();
    @(negedge clk); frd = 1'b1;
    @(negedge clk); frd = 1'b0;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL R9 watchdog expired");
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; stb = 0; bin = 1; mode = 8'h00; drd = 0; frd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset data", rx_data, 8'h00);
    chk("R9 reset flags", flags, 8'h00);

    // synchronous packing
    for (int i = 0; i < 8; i++) send_bit(1'(8'hA5 >> i));
    chk("R1 sync byte", rx_data, 8'hA5);
    chk("R6 ready", flags, 8'h08);
    for (int i = 0; i < 8; i++) send_bit(1'(8'h3C >> i));
    chk("R1 sync second", rx_data, 8'h3C);
    chk("R7 overrun", flags, 8'h18);
    rd_flags();
    chk("R8 flags read", flags, 8'h08);
    rd_data();
    chk("R6 data read", flags, 8'h00);

    // async 8 data, no parity
    mode = 8'h21;
    repeat (3) send_bit(1'b1);
    chk("R2 idle marks flags", flags, 8'h00);
    chk("R2 idle marks data", rx_data, 8'h3C);
    send_char(8'hC3, 8, 0, 0, 1);
    chk("R3 async 8-bit", rx_data, 8'hC3);
    chk("R6 async ready", flags, 8'h08);
    rd_data();

    // async 7 data
    mode = 8'h20;
    send_char(8'h2A, 7, 0, 0, 1);
    chk("R3 7-bit", rx_data, 8'h2A);
    send_char(8'hD5, 7, 0, 0, 1);
    chk("R3 7-bit top zero", rx_data, 8'h55);
    chk("R7 async overrun", flags, 8'h18);
    rd_flags(); rd_data();
    chk("R8 cleared", flags, 8'h00);

    // even parity
    mode = 8'h27;
    send_char(8'h03, 8, 1, 0, 1);
    chk("R4 even ok", flags, 8'h08);
    rd_data();
    send_char(8'h03, 8, 1, 1, 1, 1);
    chk("R4 even bad", flags, 8'h88);
    chk("R8 set wins", rx_data, 8'h03);
    rd_flags(); rd_data();

    // odd parity
    mode = 8'h25;
    send_char(8'h01, 8, 1, 0, 1);
    chk("R4 odd ok", flags, 8'h08);
    rd_data();
    send_char(8'h01, 8, 1, 1, 1);
    chk("R4 odd bad", flags, 8'h88);
    rd_flags(); rd_data();

    // framing error and hunt
    mode = 8'h21;
    send_char(8'h81, 8, 0, 0, 0);
    chk("R5 framing data", rx_data, 8'h81);
    chk("R5 framing flag", flags, 8'h48);
    rd_flags(); rd_data();
    send_bit(1'b0); send_bit(1'b0);
    for (int i = 0; i < 8; i++) send_bit(1'b0);
    chk("R5 hunt ignores zeros", flags, 8'h00);
    send_bit(1'b1);
    send_char(8'h5A, 8, 0, 0, 1);
    chk("R5 resync data", rx_data, 8'h5A);
    chk("R5 resync flags", flags, 8'h08);

    // bit_in without strobe
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); bin = 1'(i % 2);
    end
    @(negedge clk);
    chk("R10 no strobe data", rx_data, 8'h5A);
    chk("R10 no strobe flags", flags, 8'h08);

    repeat (2) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule